// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer with Per-Entry Direction Counters

This block gives an instruction fetch stage its next fetch address in the same cycle as the lookup. The fetch PC selects one entry of a direct-mapped table. Each entry holds four things: a valid flag, the upper PC bits as a tag, a predicted target address, and a 2-bit saturating direction counter. The fetch is sent to the stored target only when the tag matches in full and the counter leans towards taken. In every other case fetch continues at PC+4.

A resolve port carries the true outcome of a branch once it has executed. With it the table allocates entries for newly seen taken branches, trains the counter of an entry that hits, corrects a stale target, and removes an entry on request. In the same cycle the port compares the address the table would have predicted with the address the branch really goes to, and flags a mispredict when the two differ.

Each entry's counter is a four-state machine:
- **STRONG_NT** (code 00) and **WEAK_NT** (code 01) predict not taken.
- **WEAK_T** (code 10) and **STRONG_T** (code 11) predict taken.

Its transitions are:
- **promote**: a taken outcome moves the counter one state towards STRONG_T.
- **demote**: a not-taken outcome moves it one state towards STRONG_NT.
- **hold-high** and **hold-low**: the counter saturates at STRONG_T and at STRONG_NT.
- **seed**: a new allocation enters at WEAK_T.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses: `fetch_hit`=0, `fetch_taken`=0 and `fetch_next_pc`=`fetch_pc`+4.
- R2: With the default parameters the index is PC[7:2] (64 entries) and the tag is PC[31:8]. A hit needs the entry to be valid and all tag bits to be equal. A PC that shares an index with a stored branch but has a different tag misses.
- R3: On a hit whose counter code is 10 or 11, `fetch_taken`=1 and `fetch_next_pc` is the stored target. On a hit with code 00 or 01, `fetch_taken`=0 and `fetch_next_pc`=PC+4.
- R4: The counter is 2-bit saturating (00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken). A resolved taken outcome on a hit increments it, up to a ceiling of 11. A not-taken outcome decrements it, down to a floor of 00.
- R5: A resolved taken branch that misses allocates its indexed entry. It overwrites whatever occupied that entry, writes the tag and the target, and sets the counter to 10.
- R6: A resolved not-taken branch that misses leaves the table unchanged.
- R7: A resolved taken branch that hits replaces the stored target with `res_target`. A not-taken branch that hits leaves the stored target as it was.
- R8: `res_drop` invalidates the entry whose tag matches `res_pc`, and takes precedence over training and allocation. A drop whose tag does not match leaves the occupant unchanged.
- R9: `res_mispredict` is combinational. It is 1 exactly when `res_valid`=1 and the address predicted from the table's contents before this resolve differs from the actual next address. The actual next address is `res_target` if the branch was taken, otherwise `res_pc`+4.
- R10: A resolve write becomes visible to lookups from the first cycle after its clock edge. A lookup in the same cycle as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched |
| fetch_next_pc | output | PC_W | Predicted next fetch address |
| fetch_hit | output | 1 | Lookup matched a valid entry |
| fetch_taken | output | 1 | Redirect to the stored target |
| res_valid | input | 1 | A resolved branch is presented |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | PC_W | Actual target when taken |
| res_drop | input | 1 | Invalidate the matching entry |
| res_mispredict | output | 1 | Prediction differed from the actual next address |

## Verification
The lookup is exercised with three kinds of PC:
- PCs never written, which shows the sequential default.
- PCs that alias on the index but carry a foreign tag, which shows that a full tag compare takes place.
- PCs that hit at each counter code, which separates redirection from a plain hit.

Random resolves then draw from a small pool of four tags and four indices, so that allocation, overwriting, target rewrites and drops keep colliding on the same entries. Directed steps walk one entry through every counter state and both saturation limits. They also probe a lookup in the same cycle as a write, to separate old contents from new.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    function automatic logic ctr_says_taken(input ctr_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/btb_dir_fsm.sv
module btb_dir_fsm
    import btb_pkg::*;
(
    input  ctr_e cur_state,
    input  logic outcome_taken,
    output ctr_e next_state
);
    always_comb begin
        next_state = cur_state;
        unique case (cur_state)
            CTR_STRONG_NT: next_state = outcome_taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   next_state = outcome_taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    next_state = outcome_taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  next_state = outcome_taken ? CTR_STRONG_T : CTR_WEAK_T;
        endcase
    end
endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    localparam int TAG_W = PC_W - IDX_W - 2,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_tgt,
    input  ctr_e             wr_ctr,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_valid,
    output logic [TAG_W-1:0] ra_tag,
    output logic [PC_W-1:0]  ra_tgt,
    output ctr_e             ra_ctr,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_valid,
    output logic [TAG_W-1:0] rb_tag,
    output logic [PC_W-1:0]  rb_tgt,
    output ctr_e             rb_ctr
);
    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PC_W-1:0]  tgt_q [DEPTH];
    ctr_e             ctr_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[e] <= 1'b0;
                tag_q[e]   <= '0;
                tgt_q[e]   <= '0;
                ctr_q[e]   <= CTR_WEAK_NT;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                valid_q[e] <= wr_valid;
                tag_q[e]   <= wr_tag;
                tgt_q[e]   <= wr_tgt;
                ctr_q[e]   <= wr_ctr;
            end
        end
    end

    always_comb begin
        ra_valid = valid_q[ra_idx];
        ra_tag   = tag_q[ra_idx];
        ra_tgt   = tgt_q[ra_idx];
        ra_ctr   = ctr_q[ra_idx];
        rb_valid = valid_q[rb_idx];
        rb_tag   = tag_q[rb_idx];
        rb_tgt   = tgt_q[rb_idx];
        rb_ctr   = ctr_q[rb_idx];
    end
endmodule

// File: rtl/btb_probe.sv
module btb_probe
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    localparam int TAG_W = PC_W - IDX_W - 2
) (
    input  logic [PC_W-1:0]  pc,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [PC_W-1:0]  ent_tgt,
    input  ctr_e             ent_ctr,
    output logic             hit,
    output logic             taken,
    output logic [PC_W-1:0]  next_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    always_comb begin
        hit     = ent_valid && (pc[PC_W-1 -: TAG_W] == ent_tag);
        taken   = hit && ctr_says_taken(ent_ctr);
        next_pc = taken ? ent_tgt : (pc + STEP);
    end
endmodule

// File: rtl/btb_update.sv
module btb_update
    import btb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            res_valid,
    input  logic            res_taken,
    input  logic            res_drop,
    input  logic            res_hit,
    input  ctr_e            cur_ctr,
    input  logic [PC_W-1:0] cur_tgt,
    input  logic [PC_W-1:0] res_target,
    output logic            wr_en,
    output logic            wr_valid,
    output ctr_e            wr_ctr,
    output logic [PC_W-1:0] wr_tgt
);
    typedef enum logic [1:0] {ACT_NONE, ACT_DROP, ACT_TRAIN, ACT_ALLOC} act_e;

    act_e act;
    ctr_e trained;

    btb_dir_fsm u_fsm (
        .cur_state    (cur_ctr),
        .outcome_taken(res_taken),
        .next_state   (trained)
    );

    always_comb begin
        if (!res_valid)             act = ACT_NONE;
        else if (res_drop)          act = res_hit ? ACT_DROP : ACT_NONE;
        else if (res_hit)           act = ACT_TRAIN;
        else if (res_taken)         act = ACT_ALLOC;
        else                        act = ACT_NONE;
    end

    always_comb begin
        wr_en    = 1'b0;
        wr_valid = 1'b0;
        wr_ctr   = cur_ctr;
        wr_tgt   = cur_tgt;
        unique case (act)
            ACT_NONE: ;
            ACT_DROP: begin
                wr_en    = 1'b1;
                wr_valid = 1'b0;
            end
            ACT_TRAIN: begin
                wr_en    = 1'b1;
                wr_valid = 1'b1;
                wr_ctr   = trained;
                if (res_taken && (cur_tgt != res_target)) wr_tgt = res_target;
            end
            ACT_ALLOC: begin
                wr_en    = 1'b1;
                wr_valid = 1'b1;
                wr_ctr   = CTR_WEAK_T;
                wr_tgt   = res_target;
            end
        endcase
    end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] fetch_next_pc,
    output logic            fetch_hit,
    output logic            fetch_taken,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target,
    input  logic            res_drop,
    output logic            res_mispredict
);
    localparam int TAG_W = PC_W - IDX_W - 2;
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic [IDX_W-1:0] f_idx, r_idx;
    logic             f_valid, r_valid;
    logic [TAG_W-1:0] f_tag, r_tag;
    logic [PC_W-1:0]  f_tgt, r_tgt;
    ctr_e             f_ctr, r_ctr;

    logic             res_hit, res_pred_taken;
    logic [PC_W-1:0]  res_pred_next, res_actual_next;

    logic             wr_en, wr_valid;
    ctr_e             wr_ctr;
    logic [PC_W-1:0]  wr_tgt;

    assign f_idx = fetch_pc[2 +: IDX_W];
    assign r_idx = res_pc[2 +: IDX_W];

    btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (r_idx),
        .wr_valid(wr_valid),
        .wr_tag  (res_pc[PC_W-1 -: TAG_W]),
        .wr_tgt  (wr_tgt),
        .wr_ctr  (wr_ctr),
        .ra_idx  (f_idx),
        .ra_valid(f_valid),
        .ra_tag  (f_tag),
        .ra_tgt  (f_tgt),
        .ra_ctr  (f_ctr),
        .rb_idx  (r_idx),
        .rb_valid(r_valid),
        .rb_tag  (r_tag),
        .rb_tgt  (r_tgt),
        .rb_ctr  (r_ctr)
    );

    btb_probe #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fetch_probe (
        .pc       (fetch_pc),
        .ent_valid(f_valid),
        .ent_tag  (f_tag),
        .ent_tgt  (f_tgt),
        .ent_ctr  (f_ctr),
        .hit      (fetch_hit),
        .taken    (fetch_taken),
        .next_pc  (fetch_next_pc)
    );

    btb_probe #(.PC_W(PC_W), .IDX_W(IDX_W)) u_res_probe (
        .pc       (res_pc),
        .ent_valid(r_valid),
        .ent_tag  (r_tag),
        .ent_tgt  (r_tgt),
        .ent_ctr  (r_ctr),
        .hit      (res_hit),
        .taken    (res_pred_taken),
        .next_pc  (res_pred_next)
    );

    btb_update #(.PC_W(PC_W)) u_update (
        .res_valid (res_valid),
        .res_taken (res_taken),
        .res_drop  (res_drop),
        .res_hit   (res_hit),
        .cur_ctr   (r_ctr),
        .cur_tgt   (r_tgt),
        .res_target(res_target),
        .wr_en     (wr_en),
        .wr_valid  (wr_valid),
        .wr_ctr    (wr_ctr),
        .wr_tgt    (wr_tgt)
    );

    assign res_actual_next = res_taken ? res_target : (res_pc + STEP);
    assign res_mispredict  = res_valid && (res_pred_next != res_actual_next);

    logic unused_res_pred_taken;
    assign unused_res_pred_taken = res_pred_taken;
endmodule

// File: rtl/btb_predictor_checker.sv
module btb_predictor_checker #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic            fetch_hit,
    input logic            fetch_taken,
    input logic            res_valid,
    input logic [PC_W-1:0] res_pc,
    input logic            res_taken,
    input logic            res_drop,
    input logic            res_hit,
    input logic            res_mispredict
);
    // R3: redirection only ever comes from a hit
    a_r3_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_taken |-> fetch_hit);

    // R9: no mispredict without a resolve
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_mispredict);

    // R5: a taken resolve leaves its PC resident in the next cycle
    a_r5_taken_resident: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(res_valid && res_taken && !res_drop)
         && fetch_pc == $past(res_pc)) |-> fetch_hit);

    // R6: a missed not-taken resolve does not allocate
    a_r6_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(res_valid && !res_taken && !res_drop && !res_hit)
         && fetch_pc == $past(res_pc)) |-> !fetch_hit);

    // R8: a dropped PC misses in the next cycle
    a_r8_drop_gone: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(res_valid && res_drop)
         && fetch_pc == $past(res_pc)) |-> !fetch_hit);
endmodule

bind btb_predictor btb_predictor_checker #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_pc      (fetch_pc),
    .fetch_hit     (fetch_hit),
    .fetch_taken   (fetch_taken),
    .res_valid     (res_valid),
    .res_pc        (res_pc),
    .res_taken     (res_taken),
    .res_drop      (res_drop),
    .res_hit       (res_hit),
    .res_mispredict(res_mispredict)
);

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic [31:0] fetch_next_pc;
    logic        fetch_hit, fetch_taken;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;
    logic        res_drop = 1'b0;
    logic        res_mispredict;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    btb_predictor uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_pc(fetch_pc), .fetch_next_pc(fetch_next_pc),
        .fetch_hit(fetch_hit), .fetch_taken(fetch_taken),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .res_drop(res_drop),
        .res_mispredict(res_mispredict)
    );

    // reference model
    bit          m_v   [64];
    logic [23:0] m_tag [64];
    logic [31:0] m_tgt [64];
    logic [1:0]  m_ctr [64];

    function automatic bit m_hit(input logic [31:0] pc);
        return m_v[pc[7:2]] && (m_tag[pc[7:2]] == pc[31:8]);
    endfunction

    function automatic logic [31:0] m_next(input logic [31:0] pc);
        if (m_hit(pc) && m_ctr[pc[7:2]][1]) return m_tgt[pc[7:2]];
        return pc + 32'd4;
    endfunction

    function automatic bit m_misp(input bit v, input logic [31:0] pc,
                                  input bit t, input logic [31:0] tgt);
        logic [31:0] act;
        act = t ? tgt : pc + 32'd4;
        return v && (m_next(pc) != act);
    endfunction

    task automatic m_update(input bit v, input logic [31:0] pc, input bit t,
                            input logic [31:0] tgt, input bit drop);
        int i;
        bit h;
        i = int'(pc[7:2]);
        h = m_hit(pc);
        if (!v) return;
        if (drop) begin
            if (h) m_v[i] = 0;
        end else if (h) begin
            if (t) begin
                if (m_ctr[i] != 2'b11) m_ctr[i] = m_ctr[i] + 2'b01;
                m_tgt[i] = tgt;
            end else if (m_ctr[i] != 2'b00) m_ctr[i] = m_ctr[i] - 2'b01;
        end else if (t) begin
            m_v[i] = 1; m_tag[i] = pc[31:8]; m_tgt[i] = tgt; m_ctr[i] = 2'b10;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] fpc, input bit v, input logic [31:0] rpc,
                        input bit t, input logic [31:0] tgt, input bit drop,
                        input string req);
        @(negedge clk);
        fetch_pc = fpc; res_valid = v; res_pc = rpc; res_taken = t;
        res_target = tgt; res_drop = drop;
        #1;
        check({req, " next_pc (R3)"}, fetch_next_pc, m_next(fpc));
        check({req, " hit (R2)"}, {31'd0, fetch_hit}, {31'd0, m_hit(fpc)});
        check({req, " mispredict (R9)"}, {31'd0, res_mispredict},
              {31'd0, m_misp(v, rpc, t, tgt)});
        @(posedge clk);
        m_update(v, rpc, t, tgt, drop);
    endtask

    function automatic logic [31:0] pool_pc(input int r);
        return {24'h000100 + 24'(r % 4), 6'(4 + (r / 4) % 4), 2'b00};
    endfunction

    localparam logic [31:0] PA = 32'h0000_1010;
    localparam logic [31:0] PB = 32'h0000_2010;

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_v[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 2'b01;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        fetch_pc = 32'h0000_1000;
        #1;
        check("R1 reset next_pc", fetch_next_pc, 32'h0000_1004);
        check("R1 reset hit", {31'd0, fetch_hit}, 32'd0);
        rst_n = 1'b1;

        step(PA, 0, PA, 0, 0, 0, "R1 idle miss");
        // R10: allocating resolve and lookup of the same PC in one cycle
        step(PA, 1, PA, 1, 32'h0000_2000, 0, "R5 R10 alloc same-cycle");
        @(negedge clk); fetch_pc = PA; res_valid = 0; #1;
        check("R5 R10 target visible", fetch_next_pc, 32'h0000_2000);
        step(PB, 0, PA, 0, 0, 0, "R2 alias miss");
        step(PA, 1, PA, 1, 32'h0000_2000, 0, "R4 promote");
        step(PA, 1, PA, 1, 32'h0000_2000, 0, "R4 hold-high");
        step(PA, 1, PA, 0, 0, 0, "R4 demote to weak T");
        step(PA, 1, PA, 0, 0, 0, "R4 demote to weak NT");
        @(negedge clk); fetch_pc = PA; res_valid = 0; #1;
        check("R3 hit not-taken pc+4", fetch_next_pc, PA + 32'd4);
        check("R3 hit still set", {31'd0, fetch_hit}, 32'd1);
        step(PA, 1, PA, 0, 0, 0, "R4 demote to strong NT");
        step(PA, 1, PA, 0, 0, 0, "R4 hold-low");
        step(PA, 1, PA, 1, 32'h0000_3000, 0, "R7 promote");
        step(PA, 1, PA, 1, 32'h0000_3000, 0, "R7 target rewrite");
        @(negedge clk); fetch_pc = PA; res_valid = 0; #1;
        check("R7 new target", fetch_next_pc, 32'h0000_3000);
        step(PA, 1, PB, 0, 0, 0, "R6 not-taken miss");
        step(PB, 1, PB, 0, 0, 1, "R8 foreign drop");
        step(PA, 1, PA, 0, 0, 1, "R8 drop");
        step(PA, 0, PA, 0, 0, 0, "R8 dropped miss");
        step(PA, 1, PB, 1, 32'h0000_4000, 0, "R5 overwrite alias");
        step(PB, 0, PA, 0, 0, 0, "R5 occupant replaced");

        void'($urandom(32'd12345));
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [31:0] rpc;
            r = int'($urandom % 16);
            rpc = pool_pc(r);
            step(pool_pc(int'($urandom % 16)), ($urandom % 10) < 7, rpc,
                 ($urandom % 10) < 6, 32'h0008_0000 + 32'(($urandom % 3) * 64),
                 ($urandom % 20) == 0, "random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule